// File: doc/BRIEF.md
# Serial Control and Readout Front End for an Eight-Channel Sampling Converter

This block is the digital serial front end of an eight-channel, 12-bit sampling converter. A host holds chip select low and clocks a control byte in on the data input. The byte frames itself with a leading start bit. It carries the channel number, a polarity bit, an input-type bit and a two-bit power and clock mode. The block runs in the system clock domain. It treats the serial clock as a level input and acts on its detected rising edges (data in) and falling edges (data out, conversion start).

The conversion begins at the serial-clock falling edge that closes the eighth control bit. At that edge the block pulses `conv_go` and captures the value a converter stub presents on `conv_data`. In external-clock mode the following serial-clock falling edges pace the conversion and shift the result out at the same time, most significant bit first. In internal-clock mode an oscillator tick input times the conversion. The `sstrb` output stays low until the result is ready, and chip select may be released meanwhile. A new control byte is accepted while the previous result is still being shifted out. This allows 16-clock and 15-clock conversion cycles.

Top module: `adc_serial_if`

## Requirements
- R1: While chip select is low and no byte is in progress, DIN zeros sampled on rising SCLK edges are ignored. The first 1 begins a byte whose bits, in order, are start, channel bit 2, channel bit 1, channel bit 0, unipolar, single-ended, mode bit 1, mode bit 0. At the falling edge after the eighth bit, the fields appear on `cfg_chan`, `cfg_unipolar`, `cfg_single` and `cfg_pd`.
- R2: A byte with mode bit 1 set starts a conversion at the SCLK falling edge that follows its eighth rising edge. The block pulses `conv_go` for one cycle and captures `conv_data`.
- R3: In external-clock mode (mode bits 11), DOUT is 0 after the start edge. The next 12 SCLK falling edges drive bits 11 down to 0 of the captured value. Later falling edges drive 0.
- R4: In internal-clock mode (mode bits 10), `sstrb` goes low at the start edge and returns high after CONV_TICKS `osc_tick` pulses, with no SCLK activity needed. After that, the first 12 SCLK falling edges drive bits 11 down to 0, and earlier falling edges drive 0.
- R5: A byte with mode bit 1 clear (power-down) updates `cfg_pd` and starts no conversion. It abandons any conversion in progress, so no result-valid pulse follows and DOUT stays 0. It leaves `sstrb` high.
- R6: A start bit is accepted while a result is still being shifted out. When bytes start 16 or 15 SCLK clocks apart, both results come out intact.
- R7: `dout_oe` is low whenever `cs_n` is high. Raising `cs_n` discards a partly received byte. An internal-clock conversion keeps running while `cs_n` is high.
- R8: `res_valid` is a one-cycle pulse per completed conversion, with the conversion's channel on `res_chan`. In external-clock mode it fires at the falling edge that drives bit 0. In internal-clock mode it fires when `sstrb` rises.
- R9: An external-clock conversion that has not driven bit 0 within TMO_CYC system clock cycles of its start is dropped. No `res_valid` pulse is raised, and DOUT stays 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, sampled as a level |
| din | input | 1 | Serial control data |
| osc_tick | input | 1 | One-cycle tick of the internal conversion oscillator |
| conv_data | input | DATA_W | Conversion value from the converter core |
| conv_go | output | 1 | One-cycle pulse when a conversion starts |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for DOUT; low means high impedance |
| sstrb | output | 1 | Low while an internal-clock conversion runs |
| cfg_chan | output | CHAN_W | Latched channel number |
| cfg_unipolar | output | 1 | Latched polarity bit |
| cfg_single | output | 1 | Latched input-type bit |
| cfg_pd | output | 2 | Latched power and clock mode bits |
| res_valid | output | 1 | One-cycle pulse per completed conversion |
| res_chan | output | CHAN_W | Channel of the completed conversion |

## Verification
A wrong receive count shows up one byte later as the wrong channel on `cfg_chan`, or as a result shifted by one bit position on DOUT. A wrong shift counter shows up within a single readout as a missing, repeated or extra bit next to the result. A stuck internal-clock state shows up as `sstrb` staying low past CONV_TICKS ticks. A broken timeout shows up as a late `res_valid` pulse or as non-zero DOUT after the pause.

// File: rtl/adc_serial_if.sv
module adc_serial_if #(
  parameter int DATA_W     = 12,
  parameter int CHAN_W     = 3,
  parameter int CONV_TICKS = 13,
  parameter int TMO_CYC    = 150000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              osc_tick,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_go,
  output logic              dout,
  output logic              dout_oe,
  output logic              sstrb,
  output logic [CHAN_W-1:0] cfg_chan,
  output logic              cfg_unipolar,
  output logic              cfg_single,
  output logic [1:0]        cfg_pd,
  output logic              res_valid,
  output logic [CHAN_W-1:0] res_chan
);
  localparam int RX_W   = CHAN_W + 4;
  localparam int BYTE_N = RX_W + 1;
  localparam int RXC_W  = $clog2(BYTE_N + 1);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TICK_W = $clog2(CONV_TICKS + 1);
  localparam int TMO_W  = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXT, ST_INT} st_t;

  logic              sclk_q;
  logic              rise, fall, byte_done, tmo_abort;
  logic [RXC_W-1:0]  rx_cnt;
  logic [RX_W-1:0]   rx_sh;
  st_t               st;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  left;
  logic [TICK_W-1:0] ticks;
  logic [TMO_W-1:0]  tmr;
  logic [CHAN_W-1:0] cur_chan;

  assign rise      = sclk & ~sclk_q & ~cs_n;
  assign fall      = ~sclk & sclk_q & ~cs_n;
  assign byte_done = fall && rx_cnt == RXC_W'(BYTE_N);
  assign conv_go   = byte_done & rx_sh[1];
  assign tmo_abort = st == ST_EXT && tmr == TMO_W'(TMO_CYC - 1);
  assign dout_oe   = ~cs_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt <= '0;
      rx_sh  <= '0;
    end else if (cs_n) begin
      rx_cnt <= '0;
    end else if (rise) begin
      if (rx_cnt == '0) begin
        if (din) rx_cnt <= RXC_W'(1);
      end else if (rx_cnt < RXC_W'(BYTE_N)) begin
        rx_sh  <= {rx_sh[RX_W-2:0], din};
        rx_cnt <= rx_cnt + 1'b1;
      end
    end else if (byte_done) begin
      rx_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_chan     <= '0;
      cfg_unipolar <= 1'b0;
      cfg_single   <= 1'b0;
      cfg_pd       <= 2'b00;
    end else if (byte_done) begin
      cfg_chan     <= rx_sh[RX_W-1 -: CHAN_W];
      cfg_unipolar <= rx_sh[3];
      cfg_single   <= rx_sh[2];
      cfg_pd       <= rx_sh[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sh        <= '0;
      left      <= '0;
      dout      <= 1'b0;
      sstrb     <= 1'b1;
      ticks     <= '0;
      tmr       <= '0;
      cur_chan  <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (byte_done) begin
        dout <= 1'b0;
        if (rx_sh[1]) begin
          sh       <= conv_data;
          cur_chan <= rx_sh[RX_W-1 -: CHAN_W];
          tmr      <= '0;
          ticks    <= '0;
          if (rx_sh[0]) begin
            st    <= ST_EXT;
            left  <= CNT_W'(DATA_W);
            sstrb <= 1'b1;
          end else begin
            st    <= ST_INT;
            left  <= '0;
            sstrb <= 1'b0;
          end
        end else begin
          st    <= ST_IDLE;
          left  <= '0;
          sh    <= '0;
          sstrb <= 1'b1;
        end
      end else if (tmo_abort) begin
        st   <= ST_IDLE;
        left <= '0;
        sh   <= '0;
        dout <= 1'b0;
      end else begin
        if (st == ST_EXT) tmr <= tmr + 1'b1;
        if (fall) begin
          if (left != '0) begin
            dout <= sh[DATA_W-1];
            sh   <= sh << 1;
            left <= left - 1'b1;
            if (st == ST_EXT && left == CNT_W'(1)) begin
              res_valid <= 1'b1;
              res_chan  <= cur_chan;
              st        <= ST_IDLE;
            end
          end else begin
            dout <= 1'b0;
          end
        end
        if (st == ST_INT && osc_tick) begin
          if (ticks == TICK_W'(CONV_TICKS - 1)) begin
            st        <= ST_IDLE;
            left      <= CNT_W'(DATA_W);
            sstrb     <= 1'b1;
            res_valid <= 1'b1;
            res_chan  <= cur_chan;
          end else begin
            ticks <= ticks + 1'b1;
          end
        end
      end
    end
  end

  // R8: result-valid lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R4: strobe drops only at an internal-clock conversion start
  a_r4_strobe_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sstrb) |-> $past(conv_go) && cfg_pd == 2'b10);

  // R4: strobe rise arms a full readout
  a_r4_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> left == CNT_W'(DATA_W) || $past(byte_done));

  // R5: power-down byte leaves nothing to shift
  a_r5_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !rx_sh[1]) |=> sstrb && left == '0 && st == ST_IDLE);

  // R3: DOUT moves only on an SCLK falling edge or a timeout
  a_r3_dout_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(fall || tmo_abort));

  // R3: shift count never exceeds the result width
  a_r3_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CNT_W'(DATA_W));

  // R9: an aborted conversion reports nothing
  a_r9_tmo_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_abort && !byte_done) |=> !res_valid && left == '0);
endmodule

// File: tb/sim_adc_serial_if.sv
module sim_adc_serial_if;
  localparam int DW = 12;
  localparam int CW = 3;
  localparam int TICKS = 13;
  localparam int TMO = 600;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0, osc_tick = 1'b0;
  logic [DW-1:0] conv_data;
  logic conv_go, dout, dout_oe, sstrb, cfg_unipolar, cfg_single, res_valid;
  logic [CW-1:0] cfg_chan, res_chan;
  logic [1:0] cfg_pd;

  int checks = 0, fails = 0, conv_n = 0, vcount = 0, last_chan = 0, tick_div = 0;
  bit din_s[0:63];
  bit dout_s[0:63];
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_if #(.DATA_W(DW), .CHAN_W(CW), .CONV_TICKS(TICKS), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .osc_tick(osc_tick),
    .conv_data(conv_data), .conv_go(conv_go), .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb),
    .cfg_chan(cfg_chan), .cfg_unipolar(cfg_unipolar), .cfg_single(cfg_single), .cfg_pd(cfg_pd),
    .res_valid(res_valid), .res_chan(res_chan));

  function automatic logic [DW-1:0] stub_val(input int k);
    int v;
    v = k * 2671 + 1443;
    v = v ^ (k * 40503);
    return v[DW-1:0];
  endfunction

  assign conv_data = stub_val(conv_n);

  always @(posedge clk) begin
    if (conv_go) conv_n <= conv_n + 1;
    if (res_valid) begin vcount <= vcount + 1; last_chan <= int'(res_chan); end
    tick_div <= (tick_div == 9) ? 0 : tick_div + 1;
    osc_tick <= (tick_div == 9);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic bit_io(input bit d, output bit q);
    din = d;
    q = dout;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_stream();
    for (int i = 0; i < 64; i++) din_s[i] = 1'b0;
  endtask

  task automatic put_byte(input int pos, input int ch, input bit uni, input bit sgl, input bit [1:0] pd);
    bit [7:0] b;
    b = {1'b1, ch[2:0], uni, sgl, pd};
    for (int i = 0; i < 8; i++) din_s[pos+i] = b[7-i];
  endtask

  task automatic run_stream(input int n);
    bit q;
    for (int i = 0; i < n; i++) begin bit_io(din_s[i], q); dout_s[i] = q; end
    din = 1'b0;
  endtask

  task automatic chk_word(input int first, input int k, input string tag);
    logic [DW-1:0] got;
    for (int j = 0; j < DW; j++) got[DW-1-j] = dout_s[first+j];
    chk(got == stub_val(k), tag, int'(got), int'(stub_val(k)));
    chk(dout_s[first-1] == 1'b0 && dout_s[first+DW] == 1'b0, {tag, " zero fill"},
        int'({dout_s[first-1], dout_s[first+DW]}), 0);
  endtask

  task automatic do_ext(input int ch, input bit uni, input bit sgl, input int lead, input string tag);
    int k0, v0;
    k0 = conv_n; v0 = vcount;
    clear_stream();
    put_byte(lead, ch, uni, sgl, 2'b11);
    run_stream(lead + 24);
    chk(int'(cfg_chan) == ch && cfg_unipolar == uni && cfg_single == sgl && cfg_pd == 2'b11,
        {tag, " R1 fields"}, int'({cfg_chan, cfg_unipolar, cfg_single, cfg_pd}),
        int'({ch[2:0], uni, sgl, 2'b11}));
    chk(conv_n == k0 + 1, {tag, " R2 one conversion"}, conv_n, k0 + 1);
    chk_word(lead + 9, k0, {tag, " R3 result"});
    chk(vcount == v0 + 1 && last_chan == ch, {tag, " R8 valid"}, vcount - v0, 1);
  endtask

  task automatic do_int(input int ch, input bit drop_cs, input string tag);
    int k0, v0;
    k0 = conv_n; v0 = vcount;
    clear_stream();
    put_byte(0, ch, 1'b0, 1'b1, 2'b10);
    run_stream(8);
    chk(sstrb == 1'b0, {tag, " R4 strobe low"}, sstrb, 0);
    if (drop_cs) begin
      cs_n = 1'b1;
      @(negedge clk);
      chk(dout_oe == 1'b0, {tag, " R7 dout off"}, dout_oe, 0);
    end
    repeat (TICKS * 10 + 20) @(negedge clk);
    chk(sstrb == 1'b1, {tag, " R4 strobe high"}, sstrb, 1);
    chk(vcount == v0 + 1 && last_chan == ch, {tag, " R8 valid"}, last_chan, ch);
    cs_n = 1'b0;
    @(negedge clk);
    clear_stream();
    run_stream(14);
    chk_word(1, k0, {tag, " R4 result"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int k0, v0, ch;
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0 && sstrb == 1'b1 && res_valid == 1'b0 && dout == 1'b0, "R7 reset state",
        int'({dout_oe, sstrb, res_valid, dout}), 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);

    do_ext(5, 1'b1, 1'b0, 3, "R1 leading zeros");

    k0 = conv_n; v0 = vcount;
    clear_stream(); put_byte(0, 2, 1'b0, 1'b1, 2'b11); put_byte(16, 6, 1'b1, 1'b1, 2'b11);
    run_stream(40);
    chk_word(9, k0, "R6 16-clock first");
    chk_word(25, k0 + 1, "R6 16-clock second");
    chk(vcount == v0 + 2 && last_chan == 6, "R6 16-clock valids", vcount - v0, 2);

    k0 = conv_n; v0 = vcount;
    clear_stream(); put_byte(0, 7, 1'b0, 1'b0, 2'b11); put_byte(15, 1, 1'b0, 1'b0, 2'b11);
    run_stream(40);
    chk_word(9, k0, "R6 15-clock first");
    chk_word(24, k0 + 1, "R6 15-clock second");
    chk(vcount == v0 + 2 && last_chan == 1, "R6 15-clock valids", vcount - v0, 2);

    do_int(4, 1'b1, "R7 cs high during internal");
    do_int(0, 1'b0, "R4 internal");

    k0 = conv_n; v0 = vcount;
    clear_stream(); put_byte(0, 3, 1'b0, 1'b1, 2'b10); put_byte(8, 6, 1'b1, 1'b0, 2'b01);
    run_stream(16);
    chk(sstrb == 1'b1 && cfg_pd == 2'b01 && cfg_chan == 3'd6, "R5 power-down fields",
        int'({sstrb, cfg_pd}), 5);
    chk(conv_n == k0 + 1, "R5 no conversion started", conv_n, k0 + 1);
    repeat (TICKS * 10 + 40) @(negedge clk);
    clear_stream(); run_stream(16);
    begin
      int ones = 0;
      for (int i = 0; i < 16; i++) ones += int'(dout_s[i]);
      chk(ones == 0 && vcount == v0, "R5 abandoned conversion silent", ones + vcount - v0, 0);
    end

    v0 = vcount;
    clear_stream(); put_byte(0, 5, 1'b1, 1'b1, 2'b11);
    run_stream(10);
    repeat (TMO + 100) @(negedge clk);
    clear_stream(); run_stream(16);
    begin
      int ones = 0;
      for (int i = 0; i < 16; i++) ones += int'(dout_s[i]);
      chk(ones == 0 && vcount == v0, "R9 timeout drops result", ones + vcount - v0, 0);
    end

    clear_stream(); din_s[0] = 1'b1; din_s[1] = 1'b1; din_s[2] = 1'b0;
    run_stream(3);
    cs_n = 1'b1; repeat (4) @(negedge clk); cs_n = 1'b0; @(negedge clk);
    do_ext(3, 1'b0, 1'b1, 0, "R7 partial byte discarded");

    void'($urandom(32'd1234));
    for (int it = 0; it < 20; it++) begin
      ch = int'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) do_int(ch, bit'($urandom_range(0, 1)), "R4 random internal");
      else do_ext(ch, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                  int'($urandom_range(0, 3)), "R3 random external");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule